// File: doc/BRIEF.md
# Packet-Mode I2C Request Front End

This block is the front end of a packet-driven I2C master. Software or a DMA pushes 32-bit words into an internal transmit FIFO. Every request starts with three header words. The block decodes them into a command for a byte-level I2C engine: the 7-bit slave address, the direction, the byte count, how the transfer opens and how it closes. On writes it splits the payload words into bytes for the engine, lowest byte first. On reads it gathers the bytes the engine returns into words and places them in an internal receive FIFO. It reports how many transmit entries are free and how many receive entries hold data.

Header word 0 only identifies the packet and has no effect on the transfer. Header word 1 bits [PW-1:0] hold the byte count minus one. Header word 2 uses these fields:

| Bits | Meaning |
|------|---------|
| [7:1] | slave address |
| [0] | R/W bit |
| 16 | read flag |
| 17 | repeat-start flag |
| 18 | continue flag |

Any engine failure halts the block until reset: an unacknowledged address, unacknowledged data or lost arbitration. A header that asks for both repeat-start and continue also halts it. While halted, both FIFOs are kept flushed.

The controller has five states:

| State | Role |
|-------|------|
| `ST_HDR0`, `ST_HDR1`, `ST_HDR2` | take one header word each |
| `ST_XFER` | the engine command is live |
| `ST_HALT` | sticky error |

The transitions are:

- `ST_HDR0` goes to `ST_HDR1`, and `ST_HDR1` goes to `ST_HDR2`, when a word is available.
- `ST_HDR2` goes to `ST_XFER` on a valid header, or to `ST_HALT` on a conflicting one.
- `ST_XFER` goes back to `ST_HDR0` on `eng_done`.
- Any engine error, in any state, goes to `ST_HALT`.

Top module: `i2c_pkt_front`

## Requirements
- R1: After reset `tx_free` equals DEPTH, `rx_level` is 0, `eng_busy` is 0, `eng_begin` is 0 (fresh START) and all four error outputs are 0.
- R2: Three header words are taken before any payload word. The content of header word 0 has no effect on the command.
- R3: While `eng_busy` is high, the command fields hold steady. `eng_count` equals word 1 bits [PW-1:0] plus one, `eng_addr` equals word 2 bits [7:1] and `eng_read` equals word 2 bit 16.
- R4: On writes, `eng_tx_byte` presents payload bytes least significant byte first, one per accepted `eng_tx_valid`/`eng_tx_ready` cycle. Bytes beyond the count in the final word are dropped.
- R5: On reads, the received bytes are packed least significant byte first into words for the receive FIFO. A final partial word has its unused upper bytes at zero.
- R6: `eng_end` is 1 (close with repeated START pending) when word 2 bit 17 is set, and 2 (leave the transaction open) when word 2 bit 18 is set. Otherwise it is 0 (close with STOP).
- R7: `eng_begin` of a packet is 2 (no START) if the previous packet's end was 2, 1 (repeated START) if it was 1, and 0 otherwise.
- R8: A header with both bit 17 and bit 18 set in word 2 sets `err_hdr_conflict`, and no transfer starts.
- R9: A pulse on `eng_nack_addr`, `eng_nack_data` or `eng_arb_lost` sets the matching error output until reset. It also ends the transfer and empties both FIFOs, and later pushes are ignored.
- R10: `tx_free` drops by one for each word pushed and not yet taken. `rx_level` counts words held in the receive FIFO and drops by one on `rx_pop`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tx_push | input | 1 | write `tx_word` into the transmit FIFO |
| tx_word | input | 32 | header or payload word |
| tx_free | output | LW | empty transmit FIFO entries |
| rx_pop | input | 1 | remove the head receive word |
| rx_word | output | 32 | head of the receive FIFO |
| rx_level | output | LW | filled receive FIFO entries |
| eng_busy | output | 1 | command valid, transfer in progress |
| eng_addr | output | 7 | slave address |
| eng_read | output | 1 | 1 = read transfer |
| eng_count | output | PW+1 | bytes to transfer |
| eng_begin | output | 2 | 0 START, 1 repeated START, 2 none |
| eng_end | output | 2 | 0 STOP, 1 hold for repeated START, 2 continue |
| eng_tx_valid | output | 1 | write byte available |
| eng_tx_byte | output | 8 | write byte |
| eng_tx_ready | input | 1 | engine takes the write byte |
| eng_rx_valid | input | 1 | engine delivers a read byte |
| eng_rx_byte | input | 8 | read byte |
| eng_done | input | 1 | engine finished the transfer |
| eng_nack_addr | input | 1 | address not acknowledged |
| eng_nack_data | input | 1 | data not acknowledged |
| eng_arb_lost | input | 1 | arbitration lost |
| err_addr_nack | output | 1 | sticky address NACK flag |
| err_data_nack | output | 1 | sticky data NACK flag |
| err_arb_lost | output | 1 | sticky arbitration flag |
| err_hdr_conflict | output | 1 | sticky header conflict flag |

## Verification
The assertions assume an engine that acts only while `eng_busy` is high. It delivers read bytes no faster than one per cycle and never more than `eng_count`. It raises `eng_done` once, after the last byte, and raises error pulses only during a transfer. The directed bench stands in for the engine and keeps to these rules. It pushes whole packets that never exceed the transmit depth before they are taken, and it pops the receive FIFO only when it holds data.

// File: rtl/i2c_pkt_pkg.sv
package i2c_pkt_pkg;
    localparam int RD_FLAG_BIT = 16;
    localparam int RS_FLAG_BIT = 17;
    localparam int CT_FLAG_BIT = 18;

    typedef enum logic [1:0] {
        END_STOP    = 2'd0,
        END_RESTART = 2'd1,
        END_CONT    = 2'd2
    } end_mode_t;

    typedef enum logic [1:0] {
        BEGIN_START   = 2'd0,
        BEGIN_RESTART = 2'd1,
        BEGIN_NONE    = 2'd2
    } begin_kind_t;

    typedef enum logic [2:0] {
        ST_HDR0, ST_HDR1, ST_HDR2, ST_XFER, ST_HALT
    } state_t;
endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop, full;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    assert_level_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !push && !pop) |=> $stable(level));
endmodule

// File: rtl/pkt_decoder.sv
module pkt_decoder
    import i2c_pkt_pkg::*;
#(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   tx_rdata,
    input  logic          tx_empty,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [31:0]   rx_wdata,
    output logic          flush,
    output logic          eng_busy,
    output logic [6:0]    eng_addr,
    output logic          eng_read,
    output logic [PW:0]   eng_count,
    output logic [1:0]    eng_begin,
    output logic [1:0]    eng_end,
    output logic          eng_tx_valid,
    output logic [7:0]    eng_tx_byte,
    input  logic          eng_tx_ready,
    input  logic          eng_rx_valid,
    input  logic [7:0]    eng_rx_byte,
    input  logic          eng_done,
    input  logic          eng_nack_addr,
    input  logic          eng_nack_data,
    input  logic          eng_arb_lost,
    output logic          err_addr_nack,
    output logic          err_data_nack,
    output logic          err_arb_lost,
    output logic          err_hdr_conflict
);
    state_t      state_q, state_d;
    logic [PW:0] left_q;
    logic [31:0] buf_q, merged;
    logic [2:0]  nb_q;
    end_mode_t   end_q;
    begin_kind_t begin_q;
    logic        eng_err, conflict, hdr_take, wr_load, tx_take, rx_take;
    logic        unused_bits;

    assign unused_bits = ^tx_rdata;
    assign eng_err  = eng_nack_addr || eng_nack_data || eng_arb_lost;
    assign conflict = tx_rdata[RS_FLAG_BIT] && tx_rdata[CT_FLAG_BIT];

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HDR0: if (!tx_empty) state_d = ST_HDR1;
            ST_HDR1: if (!tx_empty) state_d = ST_HDR2;
            ST_HDR2: if (!tx_empty) state_d = conflict ? ST_HALT : ST_XFER;
            ST_XFER: if (eng_done)  state_d = ST_HDR0;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
        if (eng_err) state_d = ST_HALT;
    end

    // output process
    always_comb begin
        hdr_take     = (state_q inside {ST_HDR0, ST_HDR1, ST_HDR2}) && !tx_empty;
        wr_load      = (state_q == ST_XFER) && !eng_read && nb_q == '0
                       && left_q != '0 && !tx_empty;
        tx_pop       = hdr_take || wr_load;
        flush        = (state_q == ST_HALT);
        eng_busy     = (state_q == ST_XFER);
        eng_tx_valid = eng_busy && !eng_read && nb_q != '0 && left_q != '0;
        eng_tx_byte  = buf_q[7:0];
        tx_take      = eng_tx_valid && eng_tx_ready;
        rx_take      = eng_busy && eng_read && eng_rx_valid && left_q != '0;
        merged       = buf_q | ({24'b0, eng_rx_byte} << {nb_q[1:0], 3'b000});
        rx_push      = rx_take && (nb_q == 3'd3 || left_q == (PW+1)'(1));
        rx_wdata     = merged;
        eng_end      = end_q;
        eng_begin    = begin_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HDR0;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q    <= '0;
            eng_count <= '0;
            buf_q     <= '0;
            nb_q      <= '0;
            eng_addr  <= '0;
            eng_read  <= 1'b0;
            end_q     <= END_STOP;
            begin_q   <= BEGIN_START;
            err_addr_nack    <= 1'b0;
            err_data_nack    <= 1'b0;
            err_arb_lost     <= 1'b0;
            err_hdr_conflict <= 1'b0;
        end else begin
            err_addr_nack <= err_addr_nack || eng_nack_addr;
            err_data_nack <= err_data_nack || eng_nack_data;
            err_arb_lost  <= err_arb_lost  || eng_arb_lost;
            if (hdr_take) begin
                unique case (state_q)
                    ST_HDR0: begin
                        buf_q <= '0;
                        nb_q  <= '0;
                    end
                    ST_HDR1: begin
                        left_q    <= (PW+1)'(tx_rdata[PW-1:0]) + 1'b1;
                        eng_count <= (PW+1)'(tx_rdata[PW-1:0]) + 1'b1;
                    end
                    default: begin
                        eng_addr <= tx_rdata[7:1];
                        eng_read <= tx_rdata[RD_FLAG_BIT];
                        if (conflict) err_hdr_conflict <= 1'b1;
                        if (tx_rdata[RS_FLAG_BIT])      end_q <= END_RESTART;
                        else if (tx_rdata[CT_FLAG_BIT]) end_q <= END_CONT;
                        else                            end_q <= END_STOP;
                    end
                endcase
            end
            if (wr_load) begin
                buf_q <= tx_rdata;
                nb_q  <= 3'd4;
            end
            if (tx_take) begin
                buf_q  <= buf_q >> 8;
                nb_q   <= nb_q - 1'b1;
                left_q <= left_q - 1'b1;
            end
            if (rx_take) begin
                left_q <= left_q - 1'b1;
                if (rx_push) begin
                    buf_q <= '0;
                    nb_q  <= '0;
                end else begin
                    buf_q <= merged;
                    nb_q  <= nb_q + 1'b1;
                end
            end
            if (eng_busy && eng_done && !eng_err) begin
                unique case (end_q)
                    END_CONT:    begin_q <= BEGIN_NONE;
                    END_RESTART: begin_q <= BEGIN_RESTART;
                    default:     begin_q <= BEGIN_START;
                endcase
            end
        end
    end

    assert_cmd_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !eng_done && !eng_err) |=>
            ($stable(eng_addr) && $stable(eng_read) && $stable(eng_count) && $stable(eng_end)));
    assert_tx_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_valid |-> (eng_busy && !eng_read));
    assert_rx_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (eng_busy && eng_read));
    assert_end_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> (eng_end != 2'd3 && eng_begin != 2'd3));
    assert_conflict_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_hdr_conflict |-> !eng_busy);
    assert_sticky_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_addr_nack || err_data_nack || err_arb_lost) |=> (flush && !eng_busy && !tx_pop));
endmodule

// File: rtl/i2c_pkt_front.sv
module i2c_pkt_front #(
    parameter int DEPTH = 8,
    parameter int PW    = 12,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_push,
    input  logic [31:0]   tx_word,
    output logic [LW-1:0] tx_free,
    input  logic          rx_pop,
    output logic [31:0]   rx_word,
    output logic [LW-1:0] rx_level,
    output logic          eng_busy,
    output logic [6:0]    eng_addr,
    output logic          eng_read,
    output logic [PW:0]   eng_count,
    output logic [1:0]    eng_begin,
    output logic [1:0]    eng_end,
    output logic          eng_tx_valid,
    output logic [7:0]    eng_tx_byte,
    input  logic          eng_tx_ready,
    input  logic          eng_rx_valid,
    input  logic [7:0]    eng_rx_byte,
    input  logic          eng_done,
    input  logic          eng_nack_addr,
    input  logic          eng_nack_data,
    input  logic          eng_arb_lost,
    output logic          err_addr_nack,
    output logic          err_data_nack,
    output logic          err_arb_lost,
    output logic          err_hdr_conflict
);
    logic [31:0]   tx_rdata, rx_wdata;
    logic          tx_empty, tx_pop, rx_push, flush, rx_empty_unused;
    logic [LW-1:0] tx_level;

    pkt_fifo #(.W(32), .DEPTH(DEPTH)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(tx_push), .wdata(tx_word),
        .pop(tx_pop), .rdata(tx_rdata),
        .level(tx_level), .empty(tx_empty)
    );

    pkt_fifo #(.W(32), .DEPTH(DEPTH)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .rdata(rx_word),
        .level(rx_level), .empty(rx_empty_unused)
    );

    assign tx_free = LW'(DEPTH) - tx_level;

    pkt_decoder #(.PW(PW)) i_decoder (
        .clk(clk), .rst_n(rst_n),
        .tx_rdata(tx_rdata), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .flush(flush),
        .eng_busy(eng_busy), .eng_addr(eng_addr), .eng_read(eng_read),
        .eng_count(eng_count), .eng_begin(eng_begin), .eng_end(eng_end),
        .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
        .eng_tx_ready(eng_tx_ready), .eng_rx_valid(eng_rx_valid),
        .eng_rx_byte(eng_rx_byte), .eng_done(eng_done),
        .eng_nack_addr(eng_nack_addr), .eng_nack_data(eng_nack_data),
        .eng_arb_lost(eng_arb_lost),
        .err_addr_nack(err_addr_nack), .err_data_nack(err_data_nack),
        .err_arb_lost(err_arb_lost), .err_hdr_conflict(err_hdr_conflict)
    );
endmodule

// File: tb/test_i2c_pkt_front.sv
module test_i2c_pkt_front;
    localparam int DEPTH = 8;
    localparam int PW    = 12;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_push = 1'b0;
    logic [31:0]   tx_word = '0;
    logic [LW-1:0] tx_free, rx_level;
    logic          rx_pop = 1'b0;
    logic [31:0]   rx_word;
    logic          eng_busy, eng_read, eng_tx_valid;
    logic [6:0]    eng_addr;
    logic [PW:0]   eng_count;
    logic [1:0]    eng_begin, eng_end;
    logic [7:0]    eng_tx_byte;
    logic          eng_tx_ready = 1'b1;
    logic          eng_rx_valid = 1'b0;
    logic [7:0]    eng_rx_byte = '0;
    logic          eng_done = 1'b0;
    logic          eng_nack_addr = 1'b0, eng_nack_data = 1'b0, eng_arb_lost = 1'b0;
    logic          err_addr_nack, err_data_nack, err_arb_lost, err_hdr_conflict;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] got [16];
    int cap_addr, cap_read, cap_count, cap_begin, cap_end;

    always #5 clk = ~clk;

    i2c_pkt_front #(.DEPTH(DEPTH), .PW(PW)) i_i2c_pkt_front (.*);

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] w);
        tx_word = w;
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    function automatic logic [31:0] hdr2(input int addr, input bit rd, input bit rs, input bit ct);
        return (32'(ct) << 18) | (32'(rs) << 17) | (32'(rd) << 16) |
               (32'(addr & 7'h7f) << 1) | 32'(rd);
    endfunction

    task automatic push_hdr(input logic [31:0] w0, input int n, input logic [31:0] w2);
        push(w0);
        push(32'(n - 1));
        push(w2);
    endtask

    task automatic wait_busy_capture();
        while (!eng_busy) @(negedge clk);
        cap_addr  = eng_addr;
        cap_read  = eng_read;
        cap_count = eng_count;
        cap_begin = eng_begin;
        cap_end   = eng_end;
    endtask

    task automatic finish_xfer();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic serve_write(input int n);
        int k = 0;
        wait_busy_capture();
        while (k < n) begin
            if (eng_tx_valid) begin
                got[k] = eng_tx_byte;
                k++;
            end
            @(negedge clk);
        end
        finish_xfer();
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 tx_free", tx_free, DEPTH);
        check("R1 rx_level", rx_level, 0);
        check("R1 busy", eng_busy, 0);
        check("R1 begin", eng_begin, 0);
        check("R1 errors", {err_addr_nack, err_data_nack, err_arb_lost, err_hdr_conflict}, 0);
    endtask

    task automatic test_write_continue();
        do_reset();
        push_hdr(32'hDEAD_BEEF, 5, hdr2(7'h50, 0, 0, 1));
        push(32'h4433_2211);
        push(32'hEEFF_CC55);
        serve_write(5);
        check("R3 addr", cap_addr, 7'h50);
        check("R3 read", cap_read, 0);
        check("R3 count", cap_count, 5);
        check("R6 end continue", cap_end, 2);
        check("R7 first begin", cap_begin, 0);
        for (int i = 0; i < 5; i++) check("R4 byte order", got[i], 8'h11 * (i + 1));
        push_hdr(32'h0000_0000, 2, hdr2(7'h50, 0, 0, 0));
        push(32'h9988_BBAA);
        serve_write(2);
        check("R2 word0 ignored, count", cap_count, 2);
        check("R7 begin after continue", cap_begin, 2);
        check("R6 end stop", cap_end, 0);
        check("R4 partial word b0", got[0], 8'hAA);
        check("R4 partial word b1", got[1], 8'hBB);
        @(negedge clk);
        check("R4 extra bytes dropped", eng_tx_valid, 0);
    endtask

    task automatic test_restart_read();
        do_reset();
        push_hdr(32'h1234_5678, 1, hdr2(7'h21, 0, 1, 0));
        push(32'h0000_0077);
        serve_write(1);
        check("R6 end restart", cap_end, 1);
        check("R4 single byte", got[0], 8'h77);
        push_hdr(32'h0, 6, hdr2(7'h21, 1, 0, 0));
        wait_busy_capture();
        check("R7 begin after restart", cap_begin, 1);
        check("R3 read flag", cap_read, 1);
        check("R3 read addr", cap_addr, 7'h21);
        push(32'h0); push(32'h0); push(32'h0);
        check("R10 tx_free after 3 pushes", tx_free, DEPTH - 3);
        for (int i = 0; i < 6; i++) begin
            eng_rx_valid = 1'b1;
            eng_rx_byte  = 8'hA0 + 8'(i);
            @(negedge clk);
        end
        eng_rx_valid = 1'b0;
        finish_xfer();
        check("R10 rx_level", rx_level, 2);
        check("R5 full word", rx_word, 32'hA3A2_A1A0);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        check("R10 rx_level after pop", rx_level, 1);
        check("R5 partial word zero fill", rx_word, 32'h0000_A5A4);
    endtask

    task automatic test_conflict();
        do_reset();
        push_hdr(32'h0, 4, hdr2(7'h10, 0, 1, 1));
        push(32'h0403_0201);
        repeat (4) @(negedge clk);
        check("R8 conflict flag", err_hdr_conflict, 1);
        check("R8 no transfer", eng_busy, 0);
        check("R8 other flags", {err_addr_nack, err_data_nack, err_arb_lost}, 0);
    endtask

    task automatic test_errors();
        for (int k = 0; k < 3; k++) begin
            do_reset();
            push_hdr(32'h0, 8, hdr2(7'h33, 0, 0, 0));
            push(32'h0403_0201);
            push(32'h0807_0605);
            wait_busy_capture();
            @(negedge clk);
            eng_nack_addr = (k == 0);
            eng_nack_data = (k == 1);
            eng_arb_lost  = (k == 2);
            @(negedge clk);
            eng_nack_addr = 1'b0; eng_nack_data = 1'b0; eng_arb_lost = 1'b0;
            repeat (2) @(negedge clk);
            check("R9 flag set", {err_addr_nack, err_data_nack, err_arb_lost}, 3'b100 >> k);
            check("R9 transfer ended", eng_busy, 0);
            check("R9 tx flushed", tx_free, DEPTH);
            push(32'hCAFE_F00D);
            @(negedge clk);
            check("R9 push ignored", tx_free, DEPTH);
            repeat (5) @(negedge clk);
            check("R9 flag sticky", {err_addr_nack, err_data_nack, err_arb_lost}, 3'b100 >> k);
            check("R9 rx empty", rx_level, 0);
        end
    endtask

    initial begin
        test_reset();
        test_write_continue();
        test_restart_read();
        test_conflict();
        test_errors();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule